// File: doc/BRIEF.md
# Multiport Memory with Per-Port Capabilities

This block is a parameterized synchronous storage array shared by a set of ports that all run on one clock. Each port is given its own capability at elaboration: it may read, it may write the whole word, it may write selected fields under a mask, or it may both read and write, in which case a per-port mode input picks the operation on every edge. Each element is a packed word of equal-width fields. With the defaults there are 256 elements of two 16-bit fields, two read ports and one masked write port.

Read latency is set per port. A latency of zero gives a combinational read, and larger values add pipeline stages. Write latency is shared by all ports and is at least one edge. A read-under-write policy chooses what a pipelined read returns when its location is written while the read is still in flight. The choices are the value at issue, the value at delivery, or a poison word. Wherever the result is undefined, the block drives a fixed all-ones poison word, so that simulators that only know two states can still tell these cases apart.

Top module: `mport_mem`

## Requirements
- R1: A port with zero read latency that is enabled and not writing drives the element at its current address on its read data in the same cycle.
- R2: A port with read latency L greater than zero delivers, L cycles after issue, the element at the address that the read presented on that port.
- R3: When no read was issued on the edge a result belongs to (enable low, or mode high on a port that can also write), the read data is the poison word, all ones. A port with no read capability drives zero.
- R4: A write presented in a cycle is not visible to a combinational read in that same cycle. With write latency 1 it is visible in the next cycle.
- R5: On a masked port, wmask bit f selects field f (bits f*FW upward). Only the selected fields are updated, and a zero mask changes nothing.
- R6: A port with full-write capability writes the whole element whatever its mask input holds.
- R7: On a port that can both read and write, mode 0 reads and mode 1 writes. A read-only port ignores its mode and write data. A write-only port writes whatever its mode is.
- R8: Policy 0 (old): a pipelined read returns the element as it was on the issue edge, even if that element is written before delivery.
- R9: Policy 1 (new): a pipelined read returns the element at the delayed read address as stored at delivery.
- R10: Policy 2 (undefined): a pipelined read returns poison if any write commits to its address during its active window, which runs from the issue edge to the last edge before delivery. Otherwise it returns the stored value.
- R11: When two ports commit to the same address on one edge, every field written by both becomes all ones, and a field written by only one port takes that port's data.
- R12: A port whose enable is low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Active-low reset of pipeline valid state |
| port_en | input | NP | Per-port enable |
| port_wr | input | NP | Per-port mode, 1 selects write on ports that can read and write |
| port_addr | input | NP*AW | Per-port address, AW = clog2(DEPTH) |
| port_wdata | input | NP*FW*NF | Per-port write data |
| port_wmask | input | NP*NF | Per-port field mask, used on masked ports |
| port_rdata | output | NP*FW*NF | Per-port read data |

## Verification
On every cycle the assertions check the poison word on idle reads, the zero output of ports that cannot read, that a full write from a single port shows on a combinational read one cycle later, and that a combinational read of a fixed address holds its value across cycles with no write enabled. Field masking, latency alignment on the pipelined ports, the three read-under-write policies, and write collisions depend on sequences of stimulus across several ports. Only the bench scenarios show these, by running three instances, one per policy, in lockstep.

// File: rtl/mport_mem.sv
`timescale 1ns/1ps
module mport_mem #(
  parameter int NP = 3,
  parameter int DEPTH = 256,
  parameter int FW = 16,
  parameter int NF = 2,
  parameter logic [NP-1:0] RD_CAP = 3'b011,
  parameter logic [2*NP-1:0] WR_CAP = 6'b10_00_00,
  parameter logic [4*NP-1:0] RD_LAT = '0,
  parameter int WR_LAT = 1,
  parameter int RUW = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NP-1:0] port_en,
  input  logic [NP-1:0] port_wr,
  input  logic [NP*$clog2(DEPTH>1?DEPTH:2)-1:0] port_addr,
  input  logic [NP*FW*NF-1:0] port_wdata,
  input  logic [NP*NF-1:0] port_wmask,
  output logic [NP*FW*NF-1:0] port_rdata
);
  localparam int AW = $clog2(DEPTH > 1 ? DEPTH : 2);
  localparam int DW = FW * NF;
  localparam logic [DW-1:0] POISON = '1;

  logic [DW-1:0] store [DEPTH];

  logic [NP-1:0] c_v;
  logic [AW-1:0] c_a [NP];
  logic [DW-1:0] c_d [NP];
  logic [NF-1:0] c_m [NP];
  logic [NF-1:0] c_clash [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam logic [1:0] WC = WR_CAP[2*p +: 2];
    localparam bit RC = RD_CAP[p];
    localparam int RL = int'(RD_LAT[4*p +: 4]);

    wire [AW-1:0] a_in = port_addr[p*AW +: AW];
    wire wr_go = (WC != 2'd0) && port_en[p] && (!RC || port_wr[p]);
    wire rd_go = RC && port_en[p] && (WC == 2'd0 || !port_wr[p]);
    wire [NF-1:0] mk = (WC == 2'd2) ? port_wmask[p*NF +: NF] : '1;

    if (WR_LAT <= 1) begin : g_wnow
      assign c_v[p] = wr_go;
      assign c_a[p] = a_in;
      assign c_d[p] = port_wdata[p*DW +: DW];
      assign c_m[p] = mk;
    end else begin : g_wpipe
      logic [WR_LAT-2:0] wv;
      logic [AW-1:0] wa [WR_LAT-1];
      logic [DW-1:0] wd [WR_LAT-1];
      logic [NF-1:0] wm [WR_LAT-1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wv <= '0;
        else begin
          wv[0] <= wr_go;
          for (int k = 1; k < WR_LAT-1; k++) wv[k] <= wv[k-1];
        end
      end
      always_ff @(posedge clk) begin
        wa[0] <= a_in;
        wd[0] <= port_wdata[p*DW +: DW];
        wm[0] <= mk;
        for (int k = 1; k < WR_LAT-1; k++) begin
          wa[k] <= wa[k-1];
          wd[k] <= wd[k-1];
          wm[k] <= wm[k-1];
        end
      end
      assign c_v[p] = wv[WR_LAT-2];
      assign c_a[p] = wa[WR_LAT-2];
      assign c_d[p] = wd[WR_LAT-2];
      assign c_m[p] = wm[WR_LAT-2];
    end

    if (!RC) begin : g_nord
      assign port_rdata[p*DW +: DW] = '0;
    end else if (RL == 0) begin : g_comb
      assign port_rdata[p*DW +: DW] = rd_go ? store[a_in] : POISON;
    end else begin : g_pipe
      logic [RL-1:0] sv, sc, hit;
      logic [AW-1:0] sa [RL];
      logic [DW-1:0] sd [RL];

      always_comb begin
        hit = '0;
        for (int q = 0; q < NP; q++)
          if (c_v[q] && c_a[q] == a_in) hit[0] = 1'b1;
        for (int k = 1; k < RL; k++)
          for (int q = 0; q < NP; q++)
            if (c_v[q] && c_a[q] == sa[k-1]) hit[k] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv <= '0;
        else begin
          sv[0] <= rd_go;
          for (int k = 1; k < RL; k++) sv[k] <= sv[k-1];
        end
      end

      always_ff @(posedge clk) begin
        sa[0] <= a_in;
        sd[0] <= store[a_in];
        sc[0] <= hit[0];
        for (int k = 1; k < RL; k++) begin
          sa[k] <= sa[k-1];
          sd[k] <= sd[k-1];
          sc[k] <= sc[k-1] | hit[k];
        end
      end

      assign port_rdata[p*DW +: DW] =
        !sv[RL-1]                   ? POISON :
        (RUW == 1)                  ? store[sa[RL-1]] :
        (RUW == 2 && sc[RL-1])      ? POISON : sd[RL-1];
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      c_clash[p] = '0;
      for (int q = 0; q < NP; q++)
        if (q != p && c_v[p] && c_v[q] && c_a[p] == c_a[q])
          c_clash[p] = c_clash[p] | (c_m[p] & c_m[q]);
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++)
      for (int f = 0; f < NF; f++)
        if (c_v[p] && c_m[p][f])
          store[c_a[p]][f*FW +: FW] <= c_clash[p][f] ? {FW{1'b1}} : c_d[p][f*FW +: FW];
  end
endmodule

module mport_mem_chk #(
  parameter int NP = 3,
  parameter int DEPTH = 256,
  parameter int FW = 16,
  parameter int NF = 2,
  parameter logic [NP-1:0] RD_CAP = 3'b011,
  parameter logic [2*NP-1:0] WR_CAP = 6'b10_00_00,
  parameter logic [4*NP-1:0] RD_LAT = '0,
  parameter int WR_LAT = 1
) (
  input logic clk,
  input logic rst_n,
  input logic [NP-1:0] port_en,
  input logic [NP-1:0] port_wr,
  input logic [NP*$clog2(DEPTH>1?DEPTH:2)-1:0] port_addr,
  input logic [NP*FW*NF-1:0] port_wdata,
  input logic [NP*NF-1:0] port_wmask,
  input logic [NP*FW*NF-1:0] port_rdata
);
  localparam int AW = $clog2(DEPTH > 1 ? DEPTH : 2);
  localparam int DW = FW * NF;
  localparam logic [DW-1:0] POISON = '1;

  logic [NP-1:0] wgo, rgo, wfull;

  for (genvar p = 0; p < NP; p++) begin : g_sig
    localparam logic [1:0] WC = WR_CAP[2*p +: 2];
    localparam bit RC = RD_CAP[p];
    assign wgo[p] = (WC != 2'd0) && port_en[p] && (!RC || port_wr[p]);
    assign rgo[p] = RC && port_en[p] && (WC == 2'd0 || !port_wr[p]);
    assign wfull[p] = (WC == 2'd1) || (port_wmask[p*NF +: NF] == '1);
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    localparam bit RC = RD_CAP[p];
    localparam int RL = int'(RD_LAT[4*p +: 4]);
    wire [DW-1:0] rd = port_rdata[p*DW +: DW];
    wire [AW-1:0] ra = port_addr[p*AW +: AW];

    if (!RC) begin : g_n
      // R3
      nord_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rd == '0);
    end else if (RL == 0) begin : g_c
      // R3
      comb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rgo[p] |-> rd == POISON);
      if (WR_LAT == 1) begin : g_h
        // R12
        quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
          rgo[p] && $past(rgo[p]) && ra == $past(ra) && !$past(|wgo) |-> rd === $past(rd));
        for (genvar w = 0; w < NP; w++) begin : g_w
          if (w != p && WR_CAP[2*w +: 2] != 2'd0) begin : g_pair
            // R4
            wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
              $past(wgo[w]) && $past($countones(wgo) == 1) && $past(wfull[w]) &&
              rgo[p] && ra == $past(port_addr[w*AW +: AW])
              |-> rd === $past(port_wdata[w*DW +: DW]));
          end
        end
      end
    end else if (RL == 1) begin : g_l1
      // R3
      lat1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rgo[p]) |-> rd == POISON);
    end
  end
endmodule

bind mport_mem mport_mem_chk #(
  .NP(NP), .DEPTH(DEPTH), .FW(FW), .NF(NF),
  .RD_CAP(RD_CAP), .WR_CAP(WR_CAP), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
) chk_i (.*);

// File: tb/mport_mem_tb_top.sv
`timescale 1ns/1ps
module mport_mem_tb_top;
  localparam logic [31:0] PZ = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] en = '0, wr = '0;
  logic [31:0] addr = '0;
  logic [127:0] wdata = '0;
  logic [7:0] wmask = '0;
  logic [127:0] rd_o, rd_n, rd_u;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mport_mem #(.NP(4), .RD_CAP(4'b0111), .WR_CAP(8'b01_10_00_00), .RD_LAT(16'h0210),
              .WR_LAT(1), .RUW(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(en), .port_wr(wr), .port_addr(addr),
    .port_wdata(wdata), .port_wmask(wmask), .port_rdata(rd_o));
  mport_mem #(.NP(4), .RD_CAP(4'b0111), .WR_CAP(8'b01_10_00_00), .RD_LAT(16'h0210),
              .WR_LAT(1), .RUW(1)) dut_new_i (
    .clk(clk), .rst_n(rst_n), .port_en(en), .port_wr(wr), .port_addr(addr),
    .port_wdata(wdata), .port_wmask(wmask), .port_rdata(rd_n));
  mport_mem #(.NP(4), .RD_CAP(4'b0111), .WR_CAP(8'b01_10_00_00), .RD_LAT(16'h0210),
              .WR_LAT(1), .RUW(2)) dut_und_i (
    .clk(clk), .rst_n(rst_n), .port_en(en), .port_wr(wr), .port_addr(addr),
    .port_wdata(wdata), .port_wmask(wmask), .port_rdata(rd_u));

  function automatic logic [31:0] pick(logic [127:0] bus, int p);
    return bus[p*32 +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    en = '0; wr = '0; wmask = '0;
  endtask

  task automatic put(int p, bit w, logic [7:0] a, logic [31:0] d, logic [1:0] m);
    en[p] = 1'b1; wr[p] = w;
    addr[p*8 +: 8] = a; wdata[p*32 +: 32] = d; wmask[p*2 +: 2] = m;
  endtask

  task automatic seed(int p, logic [7:0] a, logic [31:0] d, logic [1:0] m);
    cyc(); put(p, 1'b1, a, d, m);
  endtask

  task automatic look(logic [7:0] a);
    cyc(); put(0, 1'b0, a, 32'h0, 2'b00); #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R3 reset p1 poison", pick(rd_o, 1), PZ);
    chk("R3 reset p2 poison", pick(rd_o, 2), PZ);
    chk("R3 no-read port zero", pick(rd_o, 3), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_write_timing();
    seed(2, 8'd5, 32'h1111_2222, 2'b11);
    cyc(); put(2, 1'b1, 8'd5, 32'h3333_4444, 2'b11); put(0, 1'b0, 8'd5, 32'h0, 2'b00); #1;
    chk("R4 same-cycle read sees old", pick(rd_o, 0), 32'h1111_2222);
    cyc(); put(0, 1'b0, 8'd5, 32'h0, 2'b00);
    put(3, 1'b0, 8'd5, 32'h5555_6666, 2'b11); en[3] = 1'b0; #1;
    chk("R1 R4 comb read next cycle", pick(rd_o, 0), 32'h3333_4444);
    look(8'd5);
    chk("R12 disabled write ignored", pick(rd_o, 0), 32'h3333_4444);
  endtask

  task automatic t_mask();
    seed(2, 8'd7, 32'hAAAA_BBBB, 2'b11);
    seed(2, 8'd7, 32'h1234_5678, 2'b01);
    look(8'd7);
    chk("R5 mask 01 low field", pick(rd_o, 0), 32'hAAAA_5678);
    seed(2, 8'd7, 32'h0F0F_1111, 2'b10);
    look(8'd7);
    chk("R5 mask 10 high field", pick(rd_o, 0), 32'h0F0F_5678);
    seed(2, 8'd7, 32'h4242_4242, 2'b00);
    look(8'd7);
    chk("R5 mask 00 no change", pick(rd_o, 0), 32'h0F0F_5678);
  endtask

  task automatic t_nomask();
    seed(3, 8'd8, 32'h0102_0304, 2'b00);
    look(8'd8);
    chk("R6 full write mask 00", pick(rd_o, 0), 32'h0102_0304);
    seed(3, 8'd8, 32'h0506_0708, 2'b01);
    look(8'd8);
    chk("R6 full write mask 01", pick(rd_o, 0), 32'h0506_0708);
  endtask

  task automatic t_latency();
    for (int i = 0; i < 4; i++) seed(2, 8'(10 + i), {16'h1000 + 16'(i), 16'h2000 + 16'(i)}, 2'b11);
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (i < 4) begin
        put(1, 1'b0, 8'(10 + i), 32'h0, 2'b00);
        put(2, 1'b0, 8'(13 - i), 32'h0, 2'b00);
      end
      #1;
      if (i >= 1 && i <= 4)
        chk("R2 p1 latency 1", pick(rd_o, 1), {16'h1000 + 16'(i - 1), 16'h2000 + 16'(i - 1)});
      if (i >= 2)
        chk("R2 p2 latency 2", pick(rd_o, 2), {16'h1000 + 16'(5 - i), 16'h2000 + 16'(5 - i)});
      if (i == 5) chk("R3 p1 idle poison", pick(rd_o, 1), PZ);
    end
  endtask

  task automatic t_mode();
    seed(2, 8'd40, 32'h0505_0606, 2'b11);
    cyc(); put(2, 1'b1, 8'd40, 32'h7777_1111, 2'b11); put(0, 1'b1, 8'd40, 32'h2222_3333, 2'b11); #1;
    chk("R7 read-only port ignores mode", pick(rd_o, 0), 32'h0505_0606);
    look(8'd40);
    chk("R7 mode 1 writes, read-only wdata ignored", pick(rd_o, 0), 32'h7777_1111);
    cyc(); #1;
    chk("R3 p2 in write mode gives poison", pick(rd_o, 2), PZ);
    cyc(); put(3, 1'b0, 8'd41, 32'h0A0B_0C0D, 2'b00); #1;
    look(8'd41);
    chk("R7 write-only ignores mode", pick(rd_o, 0), 32'h0A0B_0C0D);
  endtask

  task automatic t_ruw();
    seed(2, 8'd20, 32'h0A0A_1010, 2'b11);
    seed(2, 8'd21, 32'h0B0B_2020, 2'b11);
    cyc(); put(2, 1'b0, 8'd20, 32'h0, 2'b00); put(1, 1'b0, 8'd21, 32'h0, 2'b00);
    cyc(); put(3, 1'b0, 8'd20, 32'h0C0C_3030, 2'b00); #1;
    chk("R10 undefined no clash keeps value", pick(rd_u, 1), 32'h0B0B_2020);
    chk("R9 new no clash", pick(rd_n, 1), 32'h0B0B_2020);
    cyc(); #1;
    chk("R8 old in-flight", pick(rd_o, 2), 32'h0A0A_1010);
    chk("R9 new in-flight", pick(rd_n, 2), 32'h0C0C_3030);
    chk("R10 undefined in-flight", pick(rd_u, 2), PZ);
    cyc(); put(1, 1'b0, 8'd21, 32'h0, 2'b00); put(3, 1'b0, 8'd21, 32'h0D0D_4040, 2'b00);
    cyc(); #1;
    chk("R8 old same-edge", pick(rd_o, 1), 32'h0B0B_2020);
    chk("R9 new same-edge", pick(rd_n, 1), 32'h0D0D_4040);
    chk("R10 undefined same-edge", pick(rd_u, 1), PZ);
  endtask

  task automatic t_collide();
    cyc(); put(2, 1'b1, 8'd30, 32'h1111_2222, 2'b01); put(3, 1'b0, 8'd30, 32'h3333_4444, 2'b00);
    look(8'd30);
    chk("R11 shared field poison, single field kept", pick(rd_o, 0), 32'h3333_FFFF);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write_timing();
    t_mask();
    t_nomask();
    t_latency();
    t_mode();
    t_ruw();
    t_collide();
    cyc(); cyc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule